// File: doc/BRIEF.md
# Capture/Compare Interval Timer

This block measures the time between edges on an external input. Once enabled, it stays idle until the first active edge arrives on the input. That edge arms the timer, and counting starts from the preset count value. Every later active edge does four things: it stores the running count in a capture register, reloads the count to one, sets the interrupt flag and marks the period as capture-ended. The captured value therefore equals the number of prescaler ticks since the previous active edge.

If no active edge arrives, the compare value acts as a timeout. On the tick after the count reaches the compare value, the count reloads to one and the flag is set with a timeout cause. The capture register is not changed.

The input passes through a two-flop synchronizer, and edges are found by comparing successive synchronized samples. Edges act on any clock cycle. The count advances only on a prescaler tick. Software can preset the count only while the block is disabled. Clearing the enable returns the block to its idle, waiting state.

Top module: `capcmp_timer`

## Requirements
- R1: While enabled and not yet armed, the count is frozen and no flag is raised. The first active edge arms the timer without setting the flag. From the next tick on, the count increments from its preset value.
- R2: When edge_fall_i = 0 only rising input edges are active. When edge_fall_i = 1 only falling edges are active. Edges of the other direction have no effect on the flag, the count or the capture register.
- R3: An active edge while armed stores into cap_o the count held just before that edge. With one tick per clock, this value is the number of ticks since the previous active edge, or preset + interval − 1 for the first capture.
- R4: On a capture, the count reloads to 1, flag_o is set and cause_o = 1 (capture).
- R5: If the count equals cmp_i on a tick and there is no edge, the count reloads to 1 on that tick, flag_o is set, cause_o = 0 (timeout) and cap_o is unchanged. The period is therefore cmp_i ticks long after a reload.
- R6: After reset, cnt_o, cap_o, flag_o, cause_o and irq_o are all 0.
- R7: If an active edge and a timeout fall in the same cycle, the capture wins: cap_o receives the count, which equals cmp_i, and cause_o = 1.
- R8: When en_i is low, the block returns to the unarmed state and the count holds its value. A count write (cnt_wr_i) takes effect only while en_i is low. After re-enabling, the next active edge re-arms the timer and does not capture.
- R9: A flag_clr_i pulse clears both flag_o and cause_o. A capture or timeout in the same cycle takes precedence over the clear.
- R10: While armed, the count advances only when tick_i is high. Active edges are still captured in cycles without a tick.
- R11: irq_o is high exactly when flag_o and irq_en_i are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler tick; the count advances only when high |
| en_i | input | 1 | Timer enable; low returns the block to the unarmed state |
| pin_i | input | 1 | Asynchronous timer input |
| edge_fall_i | input | 1 | Active edge select: 0 = rising, 1 = falling |
| cnt_wr_i | input | 1 | Count write strobe, accepted only while disabled |
| cnt_wdata_i | input | CNT_W | Count preset value |
| cmp_i | input | CNT_W | Compare (timeout) value |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clears the flag and the cause bit |
| cnt_o | output | CNT_W | Current count |
| cap_o | output | CNT_W | Capture register |
| flag_o | output | 1 | Period-end flag |
| cause_o | output | 1 | 1 = the period ended on a capture, 0 = on a timeout |
| irq_o | output | 1 | Interrupt output |

## Verification
On every cycle, the assertions check several properties. Arming never raises the flag. A capture loads the previous count and reloads to one. A timeout reloads while leaving the capture register untouched. The count stays frozen while unarmed or between ticks. A clear without a coincident event drops the flag and the cause.

The end-to-end behaviour is shown only by the bench's sweeps, because it depends on the three-cycle synchronizer latency and on sequences of edges. These sweeps cover captured intervals for both edge polarities and a range of spacings, the ignored opposite edges, timeout periods over a range of compare values, the coincident capture/timeout case, and re-arming after a disable.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  typedef enum logic {ST_WAIT = 1'b0, ST_RUN = 1'b1} run_state_e;

  typedef struct packed {
    logic capture;
    logic timeout;
  } period_evt_t;
endpackage

// File: rtl/capcmp_sync_edge.sv
module capcmp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic edge_fall_i,
  output logic act_edge_o
);
  logic [STAGES-1:0] stg_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[0] <= 1'b0;
        else         stg_q[0] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= 1'b0;
        else         stg_q[i] <= stg_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= stg_q[STAGES-1];

  logic rise, fall;
  assign rise       = stg_q[STAGES-1] & ~prev_q;
  assign fall       = ~stg_q[STAGES-1] & prev_q;
  assign act_edge_o = edge_fall_i ? fall : rise;
endmodule

// File: rtl/capcmp_core.sv
module capcmp_core
  import capcmp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             act_edge_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             armed_o,
  output period_evt_t      evt_o
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(1);

  run_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, cap_q;
  logic             run;

  assign run           = en_i && (state_q == ST_RUN);
  assign evt_o.capture = run && act_edge_i;
  // capture outranks timeout in the same cycle
  assign evt_o.timeout = run && !act_edge_i && tick_i && (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      cap_q   <= '0;
    end else if (!en_i) begin
      state_q <= ST_WAIT;
      if (cnt_wr_i) cnt_q <= cnt_wdata_i;
    end else if (state_q == ST_WAIT) begin
      if (act_edge_i) state_q <= ST_RUN;
    end else if (evt_o.capture) begin
      cap_q <= cnt_q;
      cnt_q <= RELOAD;
    end else if (evt_o.timeout) begin
      cnt_q <= RELOAD;
    end else if (tick_i) begin
      cnt_q <= cnt_q + RELOAD;
    end
  end

  assign cnt_o   = cnt_q;
  assign cap_o   = cap_q;
  assign armed_o = (state_q == ST_RUN);
endmodule

// File: rtl/capcmp_flag.sv
module capcmp_flag
  import capcmp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  period_evt_t evt_i,
  input  logic        clr_i,
  input  logic        irq_en_i,
  output logic        flag_o,
  output logic        cause_o,
  output logic        irq_o
);
  logic flag_q, cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      cause_q <= 1'b0;
    end else if (evt_i.capture || evt_i.timeout) begin
      flag_q  <= 1'b1;
      cause_q <= evt_i.capture;
    end else if (clr_i) begin
      flag_q  <= 1'b0;
      cause_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign cause_o = cause_q;
  assign irq_o   = flag_q & irq_en_i;
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             pin_i,
  input  logic             edge_fall_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             cause_o,
  output logic             irq_o
);
  logic        act_edge;
  logic        armed;
  period_evt_t evt;

  capcmp_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .edge_fall_i(edge_fall_i),
    .act_edge_o (act_edge)
  );

  capcmp_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (tick_i),
    .act_edge_i (act_edge),
    .cnt_wr_i   (cnt_wr_i),
    .cnt_wdata_i(cnt_wdata_i),
    .cmp_i      (cmp_i),
    .cnt_o      (cnt_o),
    .cap_o      (cap_o),
    .armed_o    (armed),
    .evt_o      (evt)
  );

  capcmp_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .clr_i   (flag_clr_i),
    .irq_en_i(irq_en_i),
    .flag_o  (flag_o),
    .cause_o (cause_o),
    .irq_o   (irq_o)
  );

  // R1
  arm_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !armed && act_edge |=> armed && !$rose(flag_o) && $stable(cnt_o));

  // R1
  wait_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed && !cnt_wr_i |=> $stable(cnt_o));

  // R4
  capture_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && armed && act_edge |=>
      cap_o == $past(cnt_o) && cnt_o == CNT_W'(1) && flag_o && cause_o);

  // R5
  timeout_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && armed && !act_edge && tick_i && cnt_o == cmp_i |=>
      cnt_o == CNT_W'(1) && $stable(cap_o) && flag_o && !cause_o);

  // R8
  disable_unarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !armed);

  // R9
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && !(en_i && armed && (act_edge || (tick_i && cnt_o == cmp_i)))
      |=> !flag_o && !cause_o);

  // R10
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && armed && !act_edge && !tick_i |=> $stable(cnt_o));

  // R11
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
endmodule

// File: tb/capcmp_timer_test.sv
module capcmp_timer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b1;
  logic        en_i = 1'b0;
  logic        pin_i = 1'b0;
  logic        edge_fall_i = 1'b0;
  logic        cnt_wr_i = 1'b0;
  logic [31:0] cnt_wdata_i = '0;
  logic [31:0] cmp_i = 32'hFFFF_0000;
  logic        irq_en_i = 1'b0;
  logic        flag_clr_i = 1'b0;
  logic [31:0] cnt_o, cap_o;
  logic        flag_o, cause_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  capcmp_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i), .pin_i(pin_i),
    .edge_fall_i(edge_fall_i), .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
    .cmp_i(cmp_i), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
    .cnt_o(cnt_o), .cap_o(cap_o), .flag_o(flag_o), .cause_o(cause_o), .irq_o(irq_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // leaves the bench at N0: the negedge where the arming edge is driven
  task automatic arm_seq(input logic fall, input logic [31:0] preset);
    en_i = 1'b0;
    edge_fall_i = fall;
    pin_i = fall;
    step(4);
    cnt_wr_i = 1'b1;
    cnt_wdata_i = preset;
    step(1);
    cnt_wr_i = 1'b0;
    flag_clr_i = 1'b1;
    step(1);
    flag_clr_i = 1'b0;
    en_i = 1'b1;
    step(2);
    pin_i = ~fall;
  endtask

  initial begin
    logic [31:0] c0;
    step(3);
    rst_ni = 1'b1;
    step(1);
    chk("R6 cnt", cnt_o, 0);
    chk("R6 cap", cap_o, 0);
    chk("R6 flag", {31'b0, flag_o}, 0);
    chk("R6 cause", {31'b0, cause_o}, 0);
    chk("R6 irq", {31'b0, irq_o}, 0);

    // enabled but no edge: frozen
    en_i = 1'b1;
    step(20);
    chk("R1 frozen cnt", cnt_o, 0);
    chk("R1 no flag", {31'b0, flag_o}, 0);

    // capture sweep over polarity and spacing
    for (int sel = 0; sel < 2; sel++) begin
      for (int d = 10; d < 18; d++) begin
        logic [31:0] p;
        int h, d2;
        p = 32'(d * 7);
        h = d / 2;
        d2 = d + 3;
        irq_en_i = d[0];
        cmp_i = 32'hFFFF_0000;
        arm_seq(sel[0], p);
        step(3);
        chk("R1 armed holds preset", cnt_o, p);
        chk("R1 arming no flag", {31'b0, flag_o}, 0);
        step(1);
        chk("R1 counts after arming", cnt_o, p + 1);
        step(h - 4);
        pin_i = sel[0];
        step(d - h);
        chk("R2 opposite edge ignored flag", {31'b0, flag_o}, 0);
        chk("R2 opposite edge ignored cap", cap_o, (sel == 0 && d == 10) ? 32'd0 : cap_o);
        pin_i = ~sel[0];
        step(3);
        chk("R3 first capture", cap_o, p + 32'(d) - 1);
        chk("R4 reload", cnt_o, 1);
        chk("R4 flag", {31'b0, flag_o}, 1);
        chk("R4 cause", {31'b0, cause_o}, 1);
        chk("R11 irq", {31'b0, irq_o}, {31'b0, d[0]});
        flag_clr_i = 1'b1;
        step(1);
        flag_clr_i = 1'b0;
        chk("R9 flag cleared", {31'b0, flag_o}, 0);
        chk("R9 cause cleared", {31'b0, cause_o}, 0);
        step(h - 4);
        pin_i = sel[0];
        step(d2 - h);
        pin_i = ~sel[0];
        step(3);
        chk("R3 interval capture", cap_o, 32'(d2));
        chk("R4 second flag", {31'b0, flag_o}, 1);
      end
    end
    irq_en_i = 1'b0;

    // timeout sweep
    for (int c = 2; c < 10; c++) begin
      cmp_i = 32'(c);
      c0 = cap_o;
      arm_seq(1'b0, 32'd0);
      step(c + 3);
      chk("R5 reaches compare", cnt_o, 32'(c));
      chk("R5 no flag yet", {31'b0, flag_o}, 0);
      step(1);
      chk("R5 reload", cnt_o, 1);
      chk("R5 flag", {31'b0, flag_o}, 1);
      chk("R5 cause timeout", {31'b0, cause_o}, 0);
      chk("R5 cap unchanged", cap_o, c0);
      flag_clr_i = 1'b1;
      step(1);
      flag_clr_i = 1'b0;
      step(c - 2);
      chk("R5 second period at compare", cnt_o, 32'(c));
      step(1);
      chk("R5 second reload", cnt_o, 1);
      chk("R5 second flag", {31'b0, flag_o}, 1);
    end

    // coincident capture and timeout
    cmp_i = 32'd12;
    arm_seq(1'b0, 32'd0);
    step(6);
    pin_i = 1'b0;
    step(7);
    pin_i = 1'b1;
    step(3);
    chk("R7 capture wins value", cap_o, 32'd12);
    chk("R7 capture wins cause", {31'b0, cause_o}, 1);
    chk("R7 reload", cnt_o, 1);
    // capture one tick after timeout
    arm_seq(1'b0, 32'd0);
    step(6);
    pin_i = 1'b0;
    step(8);
    pin_i = 1'b1;
    step(3);
    chk("R7 capture after timeout", cap_o, 32'd1);
    chk("R7 cause after timeout", {31'b0, cause_o}, 1);

    // disable and re-arm
    cmp_i = 32'hFFFF_0000;
    arm_seq(1'b0, 32'd0);
    step(5);
    chk("R8 running", cnt_o, 2);
    en_i = 1'b0;
    step(1);
    cnt_wr_i = 1'b1;
    cnt_wdata_i = 32'd100;
    step(1);
    cnt_wr_i = 1'b0;
    chk("R8 preset while disabled", cnt_o, 100);
    en_i = 1'b1;
    flag_clr_i = 1'b1;
    step(1);
    flag_clr_i = 1'b0;
    cnt_wr_i = 1'b1;
    cnt_wdata_i = 32'd555;
    step(1);
    cnt_wr_i = 1'b0;
    chk("R8 write ignored when enabled", cnt_o, 100);
    pin_i = 1'b0;
    step(3);
    pin_i = 1'b1;
    step(3);
    chk("R8 re-arm no capture flag", {31'b0, flag_o}, 0);
    chk("R8 re-arm holds count", cnt_o, 100);
    step(2);
    chk("R8 counting after re-arm", cnt_o, 102);

    // tick gating
    tick_i = 1'b0;
    c0 = cnt_o;
    step(10);
    chk("R10 no tick frozen", cnt_o, c0);
    tick_i = 1'b1;
    step(5);
    tick_i = 1'b0;
    chk("R10 counts ticks", cnt_o, c0 + 5);
    pin_i = 1'b0;
    step(3);
    pin_i = 1'b1;
    step(3);
    chk("R10 capture without tick", cap_o, c0 + 5);
    chk("R10 capture flag", {31'b0, flag_o}, 1);
    tick_i = 1'b1;

    // irq mask
    irq_en_i = 1'b0;
    step(1);
    chk("R11 masked", {31'b0, irq_o}, 0);
    irq_en_i = 1'b1;
    step(1);
    chk("R11 unmasked", {31'b0, irq_o}, 1);

    // set beats clear
    flag_clr_i = 1'b1;
    step(1);
    flag_clr_i = 1'b0;
    chk("R9 cleared before race", {31'b0, flag_o}, 0);
    pin_i = 1'b0;
    step(3);
    pin_i = 1'b1;
    step(2);
    flag_clr_i = 1'b1;
    step(1);
    flag_clr_i = 1'b0;
    chk("R9 event beats clear flag", {31'b0, flag_o}, 1);
    chk("R9 event beats clear cause", {31'b0, cause_o}, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule